// File: doc/BRIEF.md
# Register-Mapped Interrupt Collector

This block gathers up to 32 interrupt lines into one request toward a processor. Each line is fixed at build time to be edge-captured or level-captured. Captured events are held in a sticky status word, filtered by a per-line enable word, and reduced to one request output. Software sees eight 32-bit words through a plain register port: it reads which lines are waiting, asks which line to service next, acknowledges lines, and changes enables.

Enables can be written whole, or changed bit by bit through a set word and a clear word, so that one driver can touch its own line without a read-modify-write race. The next-line query returns the lowest-numbered line that is both captured and enabled. When no such line exists it returns all ones, so a service loop can stop on that value.

Register reads are combinational from the current state. Writes take effect at the clock edge where `reg_wr` is high.

Top module: `irq_collector`

## Requirements
- R1: After reset the status (byte offset 0x00), enable (0x08) and master (0x1C) words read 0, the vector word (0x18) reads 0xFFFFFFFF and `irq_o` is 0.
- R2: A line whose `EDGE_MASK` bit is 1 sets its status bit only on a 0-to-1 change seen at a clock edge. A line held high after its acknowledge is not captured again.
- R3: A line whose `EDGE_MASK` bit is 0 sets its status bit at every edge where it is high. Acknowledging it while it is still high clears the bit for one cycle, and it is captured again at the next edge.
- R4: Writing the acknowledge word (0x0C) clears each status bit written as 1 and leaves the others. An acknowledge wins over a capture at the same edge.
- R5: Writing the set-enable word (0x10) sets each enable bit written as 1 and leaves the others.
- R6: Writing the clear-enable word (0x14) clears each enable bit written as 1 and leaves the others.
- R7: Writing the enable word (0x08) loads all enable bits at once.
- R8: The pending word (0x04) reads status AND enable.
- R9: The vector word reads the index of the lowest-numbered pending bit, or 0xFFFFFFFF when no bit is pending.
- R10: The master word keeps only its bits [1:0] (bit 0 enables the output, bit 1 enables line-driven requests), so writing 0xFFFFFFFF reads back 0x3. `irq_o` is 1 exactly when some pending bit is set and both master bits are 1.
- R11: Writes to the status, pending and vector words change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | NUM_SRC | Interrupt lines |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | ADDR_W | Byte offset of the addressed word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the addressed word (combinational) |
| irq_o | output | 1 | Combined interrupt request |

## Verification
A corrupted status or enable bit appears in the pending word and in the vector word in the same cycle it occurs. The request output moves with it, so one register read is enough to expose it. A wrong capture mode shows only across an acknowledge: an edge line that comes back while held high, or a level line that stays clear one cycle too long, is visible at the first read after that acknowledge. The bench therefore reads status right after each acknowledge and again one cycle later.

// File: rtl/irq_collector_pkg.sv
package irq_collector_pkg;

   localparam int unsigned WORD_W = 32;

   // byte offsets of the register words
   localparam logic [4:0] OFS_STATUS = 5'h00;
   localparam logic [4:0] OFS_PEND   = 5'h04;
   localparam logic [4:0] OFS_ENABLE = 5'h08;
   localparam logic [4:0] OFS_ACK    = 5'h0C;
   localparam logic [4:0] OFS_ENSET  = 5'h10;
   localparam logic [4:0] OFS_ENCLR  = 5'h14;
   localparam logic [4:0] OFS_VECTOR = 5'h18;
   localparam logic [4:0] OFS_MASTER = 5'h1C;

   // master word bit positions
   localparam int unsigned MST_OUT_BIT  = 0;
   localparam int unsigned MST_LINE_BIT = 1;

endpackage

// File: rtl/irq_capture.sv
module irq_capture #(
   parameter int unsigned N         = 32,
   parameter logic [31:0] EDGE_MASK = 32'h0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] src_i,
   output logic [N-1:0] set_o
);

   for (genvar g = 0; g < N; g++) begin : g_line
      if (EDGE_MASK[g]) begin : g_edge
         logic prev_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) prev_q <= 1'b0;
            else        prev_q <= src_i[g];
         end
         assign set_o[g] = src_i[g] & ~prev_q;
      end else begin : g_level
         assign set_o[g] = src_i[g];
      end
   end

endmodule

// File: rtl/irq_lowest.sv
module irq_lowest #(
   parameter int unsigned N     = 32,
   parameter int unsigned IDX_W = 5
) (
   input  logic [N-1:0]     req_i,
   output logic             any_o,
   output logic [IDX_W-1:0] idx_o
);

   always_comb begin
      any_o = |req_i;
      idx_o = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req_i[i]) idx_o = IDX_W'(i);
      end
   end

endmodule

// File: rtl/irq_collector.sv
module irq_collector
   import irq_collector_pkg::*;
#(
   parameter int unsigned NUM_SRC   = 32,
   parameter logic [31:0] EDGE_MASK = 32'h0000_00FF,
   parameter int unsigned ADDR_W    = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_i,
   input  logic               reg_wr,
   input  logic [ADDR_W-1:0]  reg_addr,
   input  logic [31:0]        reg_wdata,
   output logic [31:0]        reg_rdata,
   output logic               irq_o
);

   localparam int unsigned IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

   if (NUM_SRC < 1 || NUM_SRC > WORD_W) begin : g_bad_count
      $error("irq_collector: NUM_SRC must lie in 1..32");
   end
   if (ADDR_W < 5) begin : g_bad_addr
      $error("irq_collector: ADDR_W must be at least 5");
   end

   logic [NUM_SRC-1:0] stat_q, en_q, set_w, pend_w;
   logic [1:0]         mer_q;
   logic               any_w;
   logic [IDX_W-1:0]   idx_w;
   logic [31:0]        vec_w;
   logic [NUM_SRC-1:0] wmask;

   assign wmask = reg_wdata[NUM_SRC-1:0];

   function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [4:0] ofs);
      return a == ADDR_W'(ofs);
   endfunction

   logic wr_ack, wr_en, wr_set, wr_clr, wr_mst;
   assign wr_ack = reg_wr & hit(reg_addr, OFS_ACK);
   assign wr_en  = reg_wr & hit(reg_addr, OFS_ENABLE);
   assign wr_set = reg_wr & hit(reg_addr, OFS_ENSET);
   assign wr_clr = reg_wr & hit(reg_addr, OFS_ENCLR);
   assign wr_mst = reg_wr & hit(reg_addr, OFS_MASTER);

   irq_capture #(.N(NUM_SRC), .EDGE_MASK(EDGE_MASK)) u_capture (
      .clk   (clk),
      .rst_n (rst_n),
      .src_i (src_i),
      .set_o (set_w)
   );

   // status: acknowledge wins over a capture at the same edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stat_q <= '0;
      else        stat_q <= (stat_q | set_w) & ~(wr_ack ? wmask : '0);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      en_q <= '0;
      else if (wr_en)  en_q <= wmask;
      else if (wr_set) en_q <= en_q | wmask;
      else if (wr_clr) en_q <= en_q & ~wmask;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      mer_q <= '0;
      else if (wr_mst) mer_q <= reg_wdata[1:0];
   end

   assign pend_w = stat_q & en_q;

   irq_lowest #(.N(NUM_SRC), .IDX_W(IDX_W)) u_lowest (
      .req_i (pend_w),
      .any_o (any_w),
      .idx_o (idx_w)
   );

   assign vec_w = any_w ? 32'(idx_w) : '1;
   assign irq_o = any_w & mer_q[MST_OUT_BIT] & mer_q[MST_LINE_BIT];

   always_comb begin
      reg_rdata = '0;
      if      (hit(reg_addr, OFS_STATUS)) reg_rdata = 32'(stat_q);
      else if (hit(reg_addr, OFS_PEND))   reg_rdata = 32'(pend_w);
      else if (hit(reg_addr, OFS_ENABLE)) reg_rdata = 32'(en_q);
      else if (hit(reg_addr, OFS_VECTOR)) reg_rdata = vec_w;
      else if (hit(reg_addr, OFS_MASTER)) reg_rdata = 32'(mer_q);
   end

endmodule

// File: rtl/irq_collector_chk.sv
module irq_collector_chk #(
   parameter int unsigned N      = 32,
   parameter int unsigned ADDR_W = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_wr,
   input logic [ADDR_W-1:0] reg_addr,
   input logic [31:0]       reg_wdata,
   input logic [N-1:0]      stat,
   input logic [N-1:0]      en,
   input logic [1:0]        mer,
   input logic [31:0]       vec,
   input logic              irq_o
);

   logic [31:0] pend32;
   logic        ack_w, set_w, clr_w;
   assign pend32 = 32'(stat & en);
   assign ack_w  = reg_wr && reg_addr == ADDR_W'(5'h0C);
   assign set_w  = reg_wr && reg_addr == ADDR_W'(5'h10);
   assign clr_w  = reg_wr && reg_addr == ADDR_W'(5'h14);

   AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      ack_w |=> (stat & $past(reg_wdata[N-1:0])) == '0); // R4
   AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      !ack_w |=> ($past(stat) & ~stat) == '0); // R4
   AST_SETEN_OR: assert property (@(posedge clk) disable iff (!rst_n)
      set_w |=> en == ($past(en) | $past(reg_wdata[N-1:0]))); // R5
   AST_CLREN_ANDN: assert property (@(posedge clk) disable iff (!rst_n)
      clr_w |=> en == ($past(en) & ~$past(reg_wdata[N-1:0]))); // R6
   AST_VEC_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      pend32 == '0 |-> vec == 32'hFFFF_FFFF); // R9
   AST_VEC_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
      vec != 32'hFFFF_FFFF |-> (vec < N && pend32[vec[4:0]]
         && (pend32 & ((32'd1 << vec[4:0]) - 32'd1)) == '0)); // R9
   AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o == (mer == 2'b11 && pend32 != '0)); // R10

endmodule

bind irq_collector irq_collector_chk #(.N(NUM_SRC), .ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_wr    (reg_wr),
   .reg_addr  (reg_addr),
   .reg_wdata (reg_wdata),
   .stat      (stat_q),
   .en        (en_q),
   .mer       (mer_q),
   .vec       (vec_w),
   .irq_o     (irq_o)
);

// File: tb/test_irq_collector.sv
module test_irq_collector;

   localparam int N = 32;
   localparam time TCK = 4ns;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  src = '0;
   logic          wr = 1'b0;
   logic [4:0]    addr = '0;
   logic [31:0]   wdata = '0;
   logic [31:0]   rdata;
   logic          irq;

   int applied = 0;
   int miscmp  = 0;

   always #(TCK/2) clk = ~clk;

   irq_collector #(.NUM_SRC(N), .EDGE_MASK(32'h0000_00FF), .ADDR_W(5)) i_irq_collector (
      .clk(clk), .rst_n(rst_n), .src_i(src), .reg_wr(wr), .reg_addr(addr),
      .reg_wdata(wdata), .reg_rdata(rdata), .irq_o(irq)
   );

   task automatic tick();
      @(posedge clk); #1;
   endtask

   task automatic wreg(input logic [4:0] a, input logic [31:0] d);
      addr = a; wdata = d; wr = 1'b1;
      tick();
      wr = 1'b0;
   endtask

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      applied++;
      if (got !== exp) begin
         miscmp++;
         $display("FAIL %s: got %08h expected %08h", req, got, exp);
      end
   endtask

   task automatic rreg(input string req, input logic [4:0] a, input logic [31:0] exp);
      addr = a; #1;
      check(req, rdata, exp);
   endtask

   // {read, offset, data}: read checks data, write applies it
   localparam int NT = 16;
   localparam logic [37:0] TBL [NT] = '{
      {1'b1, 5'h08, 32'h0000_0000},   // R1 enable zero
      {1'b1, 5'h1C, 32'h0000_0000},   // R1 master zero
      {1'b1, 5'h18, 32'hFFFF_FFFF},   // R1 R9 vector empty
      {1'b0, 5'h08, 32'hA5A5_0000},   // R7 direct load
      {1'b1, 5'h08, 32'hA5A5_0000},   // R7
      {1'b0, 5'h10, 32'h0000_00F0},   // R5 set-enable
      {1'b1, 5'h08, 32'hA5A5_00F0},   // R5
      {1'b0, 5'h14, 32'hA000_0030},   // R6 clear-enable
      {1'b1, 5'h08, 32'h05A5_00C0},   // R6
      {1'b0, 5'h1C, 32'hFFFF_FFFF},   // R10 master keeps two bits
      {1'b1, 5'h1C, 32'h0000_0003},   // R10
      {1'b0, 5'h00, 32'hFFFF_FFFF},   // R11 status is read-only
      {1'b1, 5'h00, 32'h0000_0000},   // R11
      {1'b0, 5'h18, 32'h0000_0000},   // R11 vector is read-only
      {1'b1, 5'h18, 32'hFFFF_FFFF},   // R11
      {1'b1, 5'h04, 32'h0000_0000}    // R8 nothing pending
   };

   initial begin
      repeat (200000) @(posedge clk);
      miscmp++;
      $display("FAIL watchdog: got timeout expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", applied, miscmp);
      $finish;
   end

   initial begin
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      check("R1 irq", {31'd0, irq}, 32'd0);
      rreg("R1 status", 5'h00, 32'h0);

      for (int i = 0; i < NT; i++) begin
         if (TBL[i][37]) rreg($sformatf("table row %0d", i), TBL[i][36:32], TBL[i][31:0]);
         else            wreg(TBL[i][36:32], TBL[i][31:0]);
      end
      wreg(5'h08, 32'h0);
      wreg(5'h1C, 32'h3);

      // R2 edge line 3
      wreg(5'h10, 32'h0000_1008);
      src[3] = 1'b1; tick();
      rreg("R2 edge captured", 5'h00, 32'h0000_0008);
      check("R10 irq on", {31'd0, irq}, 32'd1);
      rreg("R9 vector 3", 5'h18, 32'd3);
      wreg(5'h0C, 32'h0000_0008);
      tick();
      rreg("R2 held high not recaptured", 5'h00, 32'h0);
      check("R10 irq off", {31'd0, irq}, 32'd0);
      src[3] = 1'b0; tick();
      src[3] = 1'b1; tick();
      rreg("R2 new edge", 5'h00, 32'h0000_0008);

      // R3 level line 12
      src[12] = 1'b1; tick();
      rreg("R9 lowest of two", 5'h18, 32'd3);
      wreg(5'h0C, 32'h0000_0008);
      rreg("R4 partial ack", 5'h00, 32'h0000_1000);
      rreg("R9 vector 12", 5'h18, 32'd12);
      wreg(5'h0C, 32'h0000_1000);
      rreg("R3 ack clears", 5'h00, 32'h0);
      tick();
      rreg("R3 recaptured", 5'h00, 32'h0000_1000);

      // R8 pending with line 3 disabled
      src[3] = 1'b0; tick();
      src[3] = 1'b1; tick();
      wreg(5'h14, 32'h0000_0008);
      rreg("R8 pending masks", 5'h04, 32'h0000_1000);
      rreg("R9 disabled skipped", 5'h18, 32'd12);

      // R10 master gating
      wreg(5'h1C, 32'h1);
      check("R10 line enable off", {31'd0, irq}, 32'd0);
      wreg(5'h1C, 32'h2);
      check("R10 output enable off", {31'd0, irq}, 32'd0);
      wreg(5'h1C, 32'h3);
      check("R10 both on", {31'd0, irq}, 32'd1);

      // R4 ack all once level line drops
      src = '0; tick();
      wreg(5'h0C, 32'hFFFF_FFFF);
      tick();
      rreg("R4 ack all", 5'h00, 32'h0);
      rreg("R9 empty again", 5'h18, 32'hFFFF_FFFF);

      // R1 reset in mid-run
      src[12] = 1'b1; tick();
      rst_n = 1'b0; #1;
      rreg("R1 reset status", 5'h00, 32'h0);
      rreg("R1 reset enable", 5'h08, 32'h0);
      check("R1 reset irq", {31'd0, irq}, 32'd0);

      $display("== %0d vectors applied, %0d miscompares ==", applied, miscmp);
      $finish;
   end

endmodule